// File: doc/BRIEF.md
# Read-Modify-Write Operand Transformer

This block computes the new value of an operand for read-modify-write instructions, together with the condition flag updates that each instruction produces. It supports increment, decrement, logical shifts in both directions, rotates through carry in both directions, and two bit operations that use the accumulator as a mask: one clears the selected bits and one sets them. Each operation works at either an 8-bit or a 16-bit width, chosen per request.

The requester presents the operand, the accumulator, the current carry flag, a width select and a 3-bit operation code, and qualifies them with `in_valid`. The block returns the modified operand, the values of the negative (N), zero (Z) and carry (C) flags, and one write enable for each flag. The enables tell the flag register which flags the operation updates. A flag whose enable is low is driven as 0. The output stage is registered by default. It can be removed by parameter, in which case the results are combinational.

Top module: `rmw_unit`

## Requirements
- R1: Operation code 0 (increment) and code 1 (decrement) wrap modulo 2^width. N and Z are written from the new value, and the C enable stays low.
- R2: Code 2 (shift left) moves the old top bit into C and shifts in 0 at bit 0.
- R3: Code 3 (shift right) moves the old bit 0 into C and shifts in 0 at the top bit.
- R4: Code 4 (rotate left) places the incoming carry in bit 0 and moves the old top bit into C.
- R5: Code 5 (rotate right) places the incoming carry in the top bit (bit 7 or bit 15) and moves the old bit 0 into C.
- R6: For codes 2 to 5, N is the new top bit and Z is 1 when the new value is zero. The N, Z and C enables are all high.
- R7: Code 6 (test-and-clear) sets Z when (operand AND accumulator) is zero, computed before the change, and outputs operand AND NOT accumulator.
- R8: Code 7 (test-and-set) sets Z from the same AND test and outputs operand OR accumulator. For codes 6 and 7, only the Z enable is high.
- R9: With `wide` low, only bits 7:0 of the operand and the accumulator are used, bit 7 is the top bit, and result bits 15:8 are 0. With `wide` high, all 16 bits are used and bit 15 is the top bit.
- R10: With the default registered output, `out_valid`, the result, the flags and the enables appear one clock after the request. A flag whose enable is low is driven as 0. In a cycle without a request, all enables are low.
- R11: During reset and after it, until the first request, `out_valid`, `result`, all flags and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request qualifier |
| op | input | 3 | Operation code (0 to 7) |
| wide | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| operand | input | 16 | Value to modify |
| acc | input | 16 | Accumulator, used as the bit mask |
| c_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result qualifier |
| result | output | 16 | Modified operand |
| n_out | output | 1 | New N value |
| z_out | output | 1 | New Z value |
| c_out | output | 1 | New C value |
| n_we | output | 1 | N update enable |
| z_we | output | 1 | Z update enable |
| c_we | output | 1 | C update enable |

## Verification
Every result, flag and enable from a request is due exactly one rising edge later. The bench drives each request on a falling edge and compares all outputs on the next falling edge, against a behavioural model evaluated for that same request. Idle cycles are compared in the same way, so enables that stay high after a request cannot go unnoticed. Besides the directed corner cases (all-ones and zero wrap, carry into both top-bit positions, and a mask with no bits in common with the operand), the bench sweeps a random mix of operations at both widths.

// File: rtl/rmw_unit.sv
module rmw_unit #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic        wide,
  input  logic [15:0] operand,
  input  logic [15:0] acc,
  input  logic        c_in,
  output logic        out_valid,
  output logic [15:0] result,
  output logic        n_out,
  output logic        z_out,
  output logic        c_out,
  output logic        n_we,
  output logic        z_we,
  output logic        c_we
);

  localparam logic [2:0] OP_INC = 3'd0, OP_DEC = 3'd1, OP_SHL = 3'd2, OP_SHR = 3'd3,
                         OP_ROL = 3'd4, OP_ROR = 3'd5, OP_CLR = 3'd6, OP_SET = 3'd7;

  logic [15:0] mask, opm, am, r_raw, r;
  logic        top_old, c_new, z_new, n_new;
  logic        ne, ze, ce;

  assign mask    = wide ? 16'hFFFF : 16'h00FF;
  assign opm     = operand & mask;
  assign am      = acc & mask;
  assign top_old = wide ? opm[15] : opm[7];

  always_comb begin
    r_raw = opm;
    c_new = 1'b0;
    ne    = 1'b1;
    ce    = 1'b0;
    case (op)
      OP_INC: r_raw = opm + 16'd1;
      OP_DEC: r_raw = opm - 16'd1;
      OP_SHL: begin r_raw = opm << 1; c_new = top_old; ce = 1'b1; end
      OP_SHR: begin r_raw = opm >> 1; c_new = opm[0];  ce = 1'b1; end
      OP_ROL: begin r_raw = (opm << 1) | {15'd0, c_in}; c_new = top_old; ce = 1'b1; end
      OP_ROR: begin
        r_raw = opm >> 1;
        if (wide) r_raw[15] = c_in;
        else      r_raw[7]  = c_in;
        c_new = opm[0];
        ce    = 1'b1;
      end
      OP_CLR: begin r_raw = opm & ~am; ne = 1'b0; end
      default: begin r_raw = opm | am; ne = 1'b0; end
    endcase
  end

  assign r     = r_raw & mask;
  assign n_new = ne & (wide ? r[15] : r[7]);
  assign ze    = 1'b1;
  assign z_new = (op == OP_CLR || op == OP_SET) ? ((opm & am) == 16'd0) : (r == 16'd0);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= 16'd0;
          n_out     <= 1'b0;
          z_out     <= 1'b0;
          c_out     <= 1'b0;
          n_we      <= 1'b0;
          z_we      <= 1'b0;
          c_we      <= 1'b0;
        end else begin
          out_valid <= in_valid;
          result    <= in_valid ? r : 16'd0;
          n_out     <= in_valid & n_new;
          z_out     <= in_valid & z_new;
          c_out     <= in_valid & ce & c_new;
          n_we      <= in_valid & ne;
          z_we      <= in_valid & ze;
          c_we      <= in_valid & ce;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = in_valid ? r : 16'd0;
      assign n_out     = in_valid & n_new;
      assign z_out     = in_valid & z_new;
      assign c_out     = in_valid & ce & c_new;
      assign n_we      = in_valid & ne;
      assign z_we      = in_valid & ze;
      assign c_we      = in_valid & ce;
    end
  endgenerate

endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic        wide,
  input logic [15:0] operand,
  input logic [15:0] acc,
  input logic        out_valid,
  input logic [15:0] result,
  input logic        n_out,
  input logic        z_out,
  input logic        c_out,
  input logic        n_we,
  input logic        z_we,
  input logic        c_we
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(n_we || z_we || c_we)); // R10
  AST_GATED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!n_we |-> !n_out) and (!c_we |-> !c_out)); // R10
  AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed && $past(in_valid) && $past(op) <= 3'd1) |-> (!c_we && n_we && z_we)); // R1
  AST_BITOP_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed && $past(in_valid) && $past(op) >= 3'd6) |-> (z_we && !n_we && !c_we)); // R8
  AST_BITOP_ZTEST: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed && $past(in_valid) && $past(op) >= 3'd6) |->
      (z_out == ((($past(operand) & $past(acc)) & ($past(wide) ? 16'hFFFF : 16'h00FF)) == 16'd0))); // R7
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed && $past(in_valid) && !$past(wide)) |-> (result[15:8] == 8'd0)); // R9
  AST_SHIFT_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed && $past(in_valid) && $past(op) >= 3'd2 && $past(op) <= 3'd5) |->
      (n_we && z_we && c_we)); // R6
endmodule

bind rmw_unit rmw_unit_chk #(.OUT_REG(OUT_REG)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
  .operand(operand), .acc(acc), .out_valid(out_valid), .result(result),
  .n_out(n_out), .z_out(z_out), .c_out(c_out),
  .n_we(n_we), .z_we(z_we), .c_we(c_we)
);

// File: tb/test_rmw_unit.sv
module test_rmw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        wide = 1'b0;
  logic [15:0] operand = 16'd0;
  logic [15:0] acc = 16'd0;
  logic        c_in = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        n_out, z_out, c_out, n_we, z_we, c_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rmw_unit i_rmw_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .operand(operand), .acc(acc), .c_in(c_in), .out_valid(out_valid),
    .result(result), .n_out(n_out), .z_out(z_out), .c_out(c_out),
    .n_we(n_we), .z_we(z_we), .c_we(c_we)
  );

  int e_v, e_r, e_n, e_z, e_c, e_nw, e_zw, e_cw;

  function automatic string tag_of(input int code);
    case (code)
      0, 1: return "R1";
      2: return "R2 R6";
      3: return "R3 R6";
      4: return "R4 R6";
      5: return "R5 R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input int code, input bit w, input int a, input int m, input bit ci);
    int msk = w ? 32'hFFFF : 32'hFF;
    int top = w ? 15 : 7;
    int x = a & msk;
    int k = m & msk;
    int r = 0;
    int c = 0;
    case (code)
      0: r = x + 1;
      1: r = x - 1;
      2: begin r = x * 2;            c = (x >> top) & 1; end
      3: begin r = x / 2;            c = x & 1; end
      4: begin r = x * 2 + ci;       c = (x >> top) & 1; end
      5: begin r = x / 2 + (ci << top); c = x & 1; end
      6: r = x & ~k;
      default: r = x | k;
    endcase
    r = r & msk;
    e_v = 1; e_r = r;
    e_zw = 1;
    e_nw = (code < 6) ? 1 : 0;
    e_cw = (code >= 2 && code <= 5) ? 1 : 0;
    e_n = e_nw ? ((r >> top) & 1) : 0;
    e_c = e_cw ? c : 0;
    e_z = (code >= 6) ? ((x & k) == 0) : (r == 0);
  endtask

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== e_v[0] || result !== e_r[15:0] || n_out !== e_n[0] || z_out !== e_z[0] ||
        c_out !== e_c[0] || n_we !== e_nw[0] || z_we !== e_zw[0] || c_we !== e_cw[0]) begin
      fails++;
      $display("FAIL %s: got v=%0b r=%h n=%0b z=%0b c=%0b we=%0b%0b%0b exp v=%0b r=%h n=%0b z=%0b c=%0b we=%0b%0b%0b",
        tag, out_valid, result, n_out, z_out, c_out, n_we, z_we, c_we,
        e_v[0], e_r[15:0], e_n[0], e_z[0], e_c[0], e_nw[0], e_zw[0], e_cw[0]);
    end
  endtask

  task automatic req(input int code, input bit w, input int a, input int m, input bit ci);
    in_valid = 1'b1; op = code[2:0]; wide = w; operand = a[15:0]; acc = m[15:0]; c_in = ci;
    model(code, w, a, m, ci);
    @(negedge clk);
    compare({tag_of(code), w ? " R9 R10 wide" : " R9 R10 narrow"});
  endtask

  task automatic idle();
    in_valid = 1'b0; operand = 16'hFFFF; acc = 16'hFFFF; c_in = 1'b1;
    e_v = 0; e_r = 0; e_n = 0; e_z = 0; e_c = 0; e_nw = 0; e_zw = 0; e_cw = 0;
    @(negedge clk);
    compare("R10 idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    e_v = 0; e_r = 0; e_n = 0; e_z = 0; e_c = 0; e_nw = 0; e_zw = 0; e_cw = 0;
    compare("R11 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11 after reset");

    req(0, 0, 16'h00FF, 0, 1);    // R1 wrap to zero, narrow
    req(0, 1, 16'hFFFF, 0, 1);    // R1 wrap to zero, wide
    req(1, 0, 16'h0000, 0, 0);    // R1 wrap to all ones
    req(1, 1, 16'h0000, 0, 0);
    req(0, 0, 16'hAB7F, 0, 0);    // R9 upper byte ignored
    req(2, 0, 16'h0080, 0, 1);    // R2 carry out, zero result
    req(2, 1, 16'h4001, 0, 0);
    req(3, 1, 16'h0001, 0, 1);    // R3
    req(3, 0, 16'hFF81, 0, 0);
    req(4, 0, 16'h0080, 0, 1);    // R4 carry in to bit 0
    req(4, 1, 16'h8000, 0, 0);
    req(5, 0, 16'h0001, 0, 1);    // R5 carry in to bit 7
    req(5, 1, 16'h0001, 0, 1);    // R5 carry in to bit 15
    req(5, 1, 16'h0000, 0, 0);
    idle();
    req(6, 0, 16'h00F0, 16'h000F, 0); // R7 no common bits
    req(6, 1, 16'hF0F0, 16'hFF00, 1);
    req(7, 0, 16'h0001, 16'h0081, 1); // R8
    req(7, 1, 16'h0000, 16'h0000, 0);
    idle();
    for (int i = 0; i < 400; i++) begin
      req($urandom_range(0, 7), $urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 1));
      if (i % 37 == 0) idle();
    end
    idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule